// File: doc/BRIEF.md
# Large Read Request Splitter

This block sits on the master side of a memory port. A client hands it one read command: a byte start address and a byte count of any size. The block turns that command into a series of bus read requests. Each request names an 8-byte-aligned address and a payload of one to eight 8-byte granules, so no request carries more than 64 bytes. The first request is cut short at the next 64-byte line boundary, so every later request starts on a line. The last request ends where the widened command ends.

A 3-bit optimum-size setting describes the transfer size the memory side handles best. The splitter marks a group-end flag on the request that completes each naturally aligned group of that size, and on the final request. Downstream logic can then treat the requests between two marks as one back-to-back group. The setting is captured when the command is accepted. It never changes which bytes are requested.

Top module: `rd_split`

## Requirements
- R1: A command is taken on a clock edge where `cmd_valid` and `cmd_ready` are both high; `cmd_ready` is low in every cycle in which `req_valid` is high.
- R2: The start address is rounded down and the end address (start plus count) is rounded up to multiples of 8 bytes, and the requests together cover exactly that range in ascending order.
- R3: `req_len` holds the number of 8-byte granules minus one (0 means 8 bytes, 7 means 64 bytes), and no request crosses a 64-byte boundary.
- R4: Every request after the first of a command has an address whose bits [5:0] are zero; the first request ends at the next 64-byte boundary or at the end of the range, whichever comes first.
- R5: Each request starts at the byte where the previous one ended; `req_last` is high on the final request of the command only.
- R6: A byte count of zero is accepted and yields no request; `cmd_ready` stays high afterwards.
- R7: With setting s, the group size is 64·2^min(s,3) bytes; `req_grp_end` is high when the request's end address is a multiple of the group size or the request is the last one, so setting 0 marks every request.
- R8: The addresses and lengths issued for a command do not depend on the optimum-size setting.
- R9: While `req_valid` is high and `req_ready` is low, `req_valid`, `req_addr`, `req_len`, `req_last` and `req_grp_end` stay unchanged on the next cycle.
- R10: After reset, `req_valid` is low and `cmd_ready` is high.
- R11: The optimum-size setting is taken when the command is accepted; changing `opt_size` during a split does not change the group-end marks of that split.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Splitter idle and able to take a command |
| cmd_addr | input | ADDR_W (48) | Byte start address |
| cmd_bytes | input | CNT_W (16) | Byte count |
| opt_size | input | 3 | Optimum transfer size setting |
| req_valid | output | 1 | Request offered |
| req_ready | input | 1 | Request accepted by the bus side |
| req_addr | output | ADDR_W (48) | Request byte address, 8-byte aligned |
| req_len | output | 3 | Granules minus one |
| req_last | output | 1 | Final request of the command |
| req_grp_end | output | 1 | Request closes an optimum-size group |

## Verification
Every cycle, the assertions check that requests hold while stalled and that the command side is closed while a split runs. They also check that each non-final request fills its line exactly, that requests after the first start on a line and continue from the previous end address, and that the final request always closes a group. Whether the whole sequence covers the widened range and nothing more can only be seen in the bench's scenarios. The same holds for the exact group-end pattern for each setting, the handling of zero counts, and the capture of the setting at acceptance. The bench compares each of these against a model computed from the command.

// File: rtl/rs_pkg.sv
package rs_pkg;
  localparam int GRAN_LOG = 3;   // 8-byte granule
  localparam int LINE_LOG = 3;   // granules per 64-byte line, log2
  localparam int GRP_MAX  = 3;   // cap on group size, log2 of lines

  typedef enum logic {
    S_IDLE  = 1'b0,
    S_ISSUE = 1'b1
  } split_state_e;
endpackage

// File: rtl/rs_cmd_norm.sv
module rs_cmd_norm #(
  parameter int ADDR_W = 48,
  parameter int CNT_W  = 16,
  localparam int GA_W  = ADDR_W - rs_pkg::GRAN_LOG
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [CNT_W-1:0]  bytes,
  output logic [GA_W:0]     start_g,
  output logic [GA_W:0]     end_g,
  output logic              empty
);
  logic [ADDR_W:0] sum;
  logic [2:0]      unused_lo;

  // round the exclusive end up to a granule
  assign sum = {1'b0, addr} + {{(ADDR_W+1-CNT_W){1'b0}}, bytes} + (ADDR_W+1)'(7);
  assign unused_lo = sum[2:0];
  assign end_g   = sum[ADDR_W:rs_pkg::GRAN_LOG];
  assign start_g = {1'b0, addr[ADDR_W-1:rs_pkg::GRAN_LOG]};
  assign empty   = (bytes == '0);
endmodule

// File: rtl/rs_chunk.sv
module rs_chunk #(
  parameter int GA_W = 45
) (
  input  logic [GA_W:0] cur_g,
  input  logic [GA_W:0] end_g,
  input  logic [1:0]    grp_log,
  output logic [GA_W:0] nxt_g,
  output logic [2:0]    len_code,
  output logic          last,
  output logic          grp_end
);
  logic [GA_W:0] bnd;
  logic [GA_W:0] gmask;
  logic [3:0]    units;

  // next 64-byte line boundary, in granules
  assign bnd   = {cur_g[GA_W:rs_pkg::LINE_LOG] + {{(GA_W-3){1'b0}}, 1'b1}, 3'b000};
  assign nxt_g = (bnd < end_g) ? bnd : end_g;
  assign units = nxt_g[3:0] - cur_g[3:0];
  assign len_code = 3'(units - 4'd1);
  assign last  = (nxt_g == end_g);
  assign gmask = ((GA_W+1)'(8) << grp_log) - (GA_W+1)'(1);
  assign grp_end = last || ((nxt_g & gmask) == '0);
endmodule

// File: rtl/rd_split.sv
module rd_split #(
  parameter int ADDR_W = 48,
  parameter int CNT_W  = 16,
  localparam int GA_W  = ADDR_W - rs_pkg::GRAN_LOG
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [CNT_W-1:0]  cmd_bytes,
  input  logic [2:0]        opt_size,
  output logic              req_valid,
  input  logic              req_ready,
  output logic [ADDR_W-1:0] req_addr,
  output logic [2:0]        req_len,
  output logic              req_last,
  output logic              req_grp_end
);
  import rs_pkg::*;

  split_state_e state_q, state_d;
  logic [GA_W:0] cur_q, cur_d, end_q, end_d;
  logic [1:0]    grp_q, grp_d;
  logic          reg_en;

  logic [GA_W:0] n_start, n_end, c_nxt;
  logic          n_empty, c_last;
  logic [1:0]    grp_sel;
  logic          accept, advance;

  rs_cmd_norm #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_norm (
    .addr(cmd_addr), .bytes(cmd_bytes),
    .start_g(n_start), .end_g(n_end), .empty(n_empty)
  );

  rs_chunk #(.GA_W(GA_W)) u_chunk (
    .cur_g(cur_q), .end_g(end_q), .grp_log(grp_q),
    .nxt_g(c_nxt), .len_code(req_len), .last(c_last), .grp_end(req_grp_end)
  );

  assign grp_sel   = (opt_size > 3'(GRP_MAX)) ? 2'(GRP_MAX) : opt_size[1:0];
  assign cmd_ready = (state_q == S_IDLE);
  assign req_valid = (state_q == S_ISSUE);
  assign accept    = cmd_valid && cmd_ready && !n_empty;
  assign advance   = req_valid && req_ready;

  always_comb begin
    state_d = state_q;
    cur_d   = cur_q;
    end_d   = end_q;
    grp_d   = grp_q;
    reg_en  = 1'b0;
    if (accept) begin
      state_d = S_ISSUE;
      cur_d   = n_start;
      end_d   = n_end;
      grp_d   = grp_sel;
      reg_en  = 1'b1;
    end else if (advance) begin
      cur_d  = c_nxt;
      reg_en = 1'b1;
      if (c_last) state_d = S_IDLE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      cur_q   <= '0;
      end_q   <= '0;
      grp_q   <= '0;
    end else if (reg_en) begin
      state_q <= state_d;
      cur_q   <= cur_d;
      end_q   <= end_d;
      grp_q   <= grp_d;
    end
  end

  assign req_addr = {cur_q[GA_W-1:0], 3'b000};
  assign req_last = c_last;
endmodule

// File: rtl/rs_checker.sv
module rs_checker #(
  parameter int ADDR_W = 48
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_ready,
  input logic              req_valid,
  input logic              req_ready,
  input logic [ADDR_W-1:0] req_addr,
  input logic [2:0]        req_len,
  input logic              req_last,
  input logic              req_grp_end
);
  logic              mid_q;
  logic [ADDR_W-1:0] exp_addr_q;
  logic [ADDR_W-1:0] step;

  assign step = ADDR_W'({req_len, 3'b000}) + ADDR_W'(8);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mid_q      <= 1'b0;
      exp_addr_q <= '0;
    end else if (req_valid && req_ready) begin
      mid_q      <= !req_last;
      exp_addr_q <= req_addr + step;
    end
  end

  p_busy_r1: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> !cmd_ready);

  p_fill_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_last) |-> (3'(req_addr[5:3] + req_len) == 3'd7));

  p_line_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && mid_q) |-> (req_addr[5:0] == 6'd0));

  p_contig_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && mid_q) |-> (req_addr == exp_addr_q));

  p_lastgrp_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_last) |-> req_grp_end);

  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |=> (req_valid && $stable(req_addr) && $stable(req_len)
                                   && $stable(req_last) && $stable(req_grp_end)));
endmodule

bind rd_split rs_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_ready(cmd_ready),
  .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
  .req_len(req_len), .req_last(req_last), .req_grp_end(req_grp_end)
);

// File: tb/sim_rd_split.sv
`timescale 1ns/1ps
module sim_rd_split;
  logic        clk, rst_n;
  logic        cmd_valid, cmd_ready;
  logic [47:0] cmd_addr;
  logic [15:0] cmd_bytes;
  logic [2:0]  opt_size;
  logic        req_valid, req_ready;
  logic [47:0] req_addr;
  logic [2:0]  req_len;
  logic        req_last, req_grp_end;

  int checks = 0;
  int fails  = 0;

  longint m_cur, m_end;
  int     m_s;
  longint seq_sum;
  int     seq_cnt;

  rd_split u0 (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_addr(cmd_addr), .cmd_bytes(cmd_bytes), .opt_size(opt_size),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .req_len(req_len), .req_last(req_last), .req_grp_end(req_grp_end)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // run one command; stall_pct = chance of req_ready low; flip changes opt_size mid-split
  task automatic run_cmd(input longint addr, input int bytes, input int s,
                         input int stall_pct, input bit flip);
    bit     held = 0;
    longint h_addr = 0;
    int     h_len = 0;
    bit     h_last = 0, h_grp = 0;
    bit     done = 0;
    @(negedge clk);
    cmd_valid = 1'b1;
    cmd_addr  = addr[47:0];
    cmd_bytes = bytes[15:0];
    opt_size  = s[2:0];
    chk(cmd_ready == 1'b1, "R1 ready when idle", longint'(cmd_ready), 1);
    m_cur = addr / 8;
    m_end = (addr + longint'(bytes) + 7) / 8;
    m_s   = s;
    seq_sum = 0;
    seq_cnt = 0;
    @(negedge clk);
    cmd_valid = 1'b0;
    if (flip) opt_size = 3'(~s);
    if (bytes == 0) begin
      chk(req_valid == 1'b0 && cmd_ready == 1'b1, "R6 zero count", longint'({req_valid, cmd_ready}), 1);
      done = 1;
    end
    while (!done) begin
      req_ready = ($urandom_range(0, 99) >= stall_pct);
      chk(req_valid == 1'b1, "R5 sequence continues", longint'(req_valid), 1);
      chk(cmd_ready == 1'b0, "R1 busy", longint'(cmd_ready), 0);
      if (held)
        chk(longint'(req_addr) == h_addr && int'(req_len) == h_len &&
            req_last == h_last && req_grp_end == h_grp, "R9 hold",
            longint'(req_addr), h_addr);
      if (req_valid && req_ready) begin
        longint bnd, ce, gsz;
        bit     e_last, e_grp;
        int     sc;
        bnd = (m_cur / 8 + 1) * 8;
        ce  = (bnd < m_end) ? bnd : m_end;
        e_last = (ce == m_end);
        sc  = (m_s > 3) ? 3 : m_s;
        gsz = longint'(8) << sc;
        e_grp = e_last || (ce % gsz == 0);
        chk(longint'(req_addr) == m_cur * 8, "R2 R4 address", longint'(req_addr), m_cur * 8);
        chk(longint'(req_len) == ce - m_cur - 1, "R3 length", longint'(req_len), ce - m_cur - 1);
        chk(req_last == e_last, "R5 last", longint'(req_last), longint'(e_last));
        chk(req_grp_end == e_grp, "R7 R11 group end", longint'(req_grp_end), longint'(e_grp));
        seq_sum += longint'(req_addr) * 3 + longint'(req_len);
        seq_cnt++;
        m_cur = ce;
        if (e_last) done = 1;
        held = 0;
      end else begin
        held   = 1;
        h_addr = longint'(req_addr);
        h_len  = int'(req_len);
        h_last = req_last;
        h_grp  = req_grp_end;
      end
      @(negedge clk);
    end
    req_ready = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    longint s_a, s_b;
    int     c_a, c_b;
    void'($urandom(32'd4242));
    rst_n = 1'b0; cmd_valid = 1'b0; cmd_addr = '0; cmd_bytes = '0;
    opt_size = '0; req_ready = 1'b0;
    repeat (3) @(negedge clk);
    chk(req_valid == 1'b0 && cmd_ready == 1'b1, "R10 reset", longint'({req_valid, cmd_ready}), 1);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_valid == 1'b0 && cmd_ready == 1'b1, "R10 after release", longint'({req_valid, cmd_ready}), 1);

    // directed corners
    run_cmd(64'h1000, 64, 0, 0, 0);      // one full line
    run_cmd(64'h1003, 1, 2, 0, 0);       // one byte, widened
    run_cmd(64'h1007, 2, 1, 30, 0);      // straddles a granule
    run_cmd(64'h103C, 8, 3, 0, 0);       // crosses a line
    run_cmd(64'h2000, 0, 5, 0, 0);       // R6 zero
    chk(cmd_ready == 1'b1, "R6 idle after zero", longint'(cmd_ready), 1);
    run_cmd(64'h2028, 1200, 7, 40, 0);   // long, capped group
    run_cmd(64'h4010, 900, 1, 20, 1);    // R11 setting changes mid-split

    // R8: same command under two settings gives same requests
    run_cmd(64'h5018, 700, 0, 25, 0);
    s_a = seq_sum; c_a = seq_cnt;
    run_cmd(64'h5018, 700, 7, 25, 0);
    s_b = seq_sum; c_b = seq_cnt;
    chk(s_a == s_b && c_a == c_b, "R8 setting independence", s_b, s_a);

    for (int i = 0; i < 250; i++) begin
      longint a;
      a = ((longint'($urandom) << 16) ^ longint'($urandom)) & 64'h7FFF_FFFF_FFFF;
      run_cmd(a, $urandom_range(0, 1500), $urandom_range(0, 7),
              $urandom_range(0, 50), ($urandom_range(0, 3) == 0));
    end

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule